// File: doc/BRIEF.md
# Drawing Command FIFO Front-End

This block sits between a host register port and a pixel engine. Host code writes 32-bit command and argument words into a small command FIFO through a single data address. Before writing a packet, it polls a free-slot count and a composite status word. A parser pops words from the FIFO. It reads each header to learn the packet type and how many argument words follow, gathers those arguments, and presents one decoded drawing request to the pixel engine. A request is either a rectangle fill or a block copy, and it is offered on a valid/ready handshake.

The block also holds the persistent drawing state that the host writes directly: the fill colour, the line pitch in pixels, the four edges of the clip window, and the pixel-size mode that a mode-setup packet selects. Headers the parser does not recognise are dropped. FIFO writes that arrive while the FIFO is full are discarded. Either event sets a sticky error flag. A soft-reset input empties the FIFO, abandons any half-received packet, withdraws a pending request and clears the error. The persistent drawing state survives a soft reset.

Top module: `draw_cmd_front`

## Requirements
- R1: After reset the free-slot register (address 1) reads DEPTH, the status register (address 2) reads 0, and both reqValid and errFlag are low.
- R2: The free-slot register reads DEPTH minus the number of words held in the FIFO. Words written to address 0 enter the FIFO in order.
- R3: A fill packet is three words: header 0x09410000, then the destination (y in bits 31:16, x in bits 15:0), then the size (height in bits 31:16, width in bits 15:0). It produces one request with reqIsCopy=0, reqSrcX=reqSrcY=0 and reqColor equal to the colour register (address 3) at the moment the last word is parsed. Later colour writes do not alter a request that is already decoded.
- R4: A header whose bits 31:24 equal 0x0D starts a four-word copy packet: source, destination and size, each packed as y<<16|x or height<<16|width. It produces one request with reqIsCopy=1.
- R5: Header 0xF1010108 starts a two-word mode packet. Bit 15 of the second word sets cfgPix16 (1 for 16-bit pixels, 0 for 8-bit). No request is produced.
- R6: The status register has bit 0 set when the FIFO is not empty, bit 4 set while a packet is partly parsed, bit 5 set while a request waits for acceptance, and bit 8 equal to engBusy. Bit 16 mirrors errFlag. Within the mask 0x131 the register reads zero only when the FIFO is empty and nothing is in flight.
- R7: While reqValid is high and reqReady is low, reqValid stays high and every request field stays stable. No FIFO word is consumed until the handshake completes.
- R8: A header matching no known packet is dropped and sets errFlag. The word after it is parsed as a header.
- R9: A write to address 0 while the FIFO holds DEPTH words is discarded and sets errFlag.
- R10: Addresses 4, 5, 6, 7 and 8 hold the pitch, clip x min, clip x max, clip y min and clip y max in their low 16 bits. Each appears on its output port and reads back at its address.
- R11: errFlag stays set until a soft reset. A soft reset empties the FIFO, discards a partial packet, drops a pending request and clears errFlag. The colour, pitch, clip and pixel-mode registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous soft reset of the command path |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 4 | Host register address |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data for regAddr (combinational) |
| engBusy | input | 1 | Pixel engine reports work in progress |
| reqValid | output | 1 | Decoded request offered |
| reqReady | input | 1 | Pixel engine accepts the request |
| reqIsCopy | output | 1 | 1 for block copy, 0 for fill |
| reqSrcX | output | 16 | Copy source x |
| reqSrcY | output | 16 | Copy source y |
| reqDstX | output | 16 | Destination x |
| reqDstY | output | 16 | Destination y |
| reqWidth | output | 16 | Region width |
| reqHeight | output | 16 | Region height |
| reqColor | output | 32 | Fill colour captured with a fill request |
| cfgPix16 | output | 1 | 1 selects 16-bit pixels |
| cfgPitch | output | 16 | Line pitch in pixels |
| clipXMin | output | 16 | Clip window left edge |
| clipXMax | output | 16 | Clip window right edge |
| clipYMin | output | 16 | Clip window top edge |
| clipYMax | output | 16 | Clip window bottom edge |
| errFlag | output | 1 | Sticky error for bad header or overflow |

## Verification
The test sends a fill and then a copy while the engine holds ready low. This shows that a pending request freezes the parser and that the colour is captured at decode time, because the colour changes while the fill waits. Mode packets are sent with bit 15 set and then clear; they must change cfgPix16 and produce no request. A half-sent copy followed by a soft reset tests the partial-packet status bit and checks that the stored drawing state survives. A bad header ahead of a valid fill, and a FIFO filled to exactly DEPTH words followed by one more write, test the two error sources and show which words are lost and which are kept.

// File: rtl/draw_cmd_pkg.sv
package draw_cmd_pkg;
  localparam int WORD_W  = 32;
  localparam int COORD_W = 16;
  localparam int ADDR_W  = 4;
  localparam int ARG_SLOTS = 3;

  localparam logic [WORD_W-1:0] HDR_FILL = 32'h0941_0000;
  localparam logic [WORD_W-1:0] HDR_MODE = 32'hF101_0108;
  localparam logic [7:0]        OP_COPY  = 8'h0D;

  localparam logic [1:0] LEN_FILL = 2'd2;
  localparam logic [1:0] LEN_COPY = 2'd3;
  localparam logic [1:0] LEN_MODE = 2'd1;

  localparam logic [ADDR_W-1:0] A_FIFO   = 4'd0;
  localparam logic [ADDR_W-1:0] A_SLOTS  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd2;
  localparam logic [ADDR_W-1:0] A_COLOR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PITCH  = 4'd4;
  localparam logic [ADDR_W-1:0] A_XMIN   = 4'd5;
  localparam logic [ADDR_W-1:0] A_XMAX   = 4'd6;
  localparam logic [ADDR_W-1:0] A_YMIN   = 4'd7;
  localparam logic [ADDR_W-1:0] A_YMAX   = 4'd8;

  localparam int ST_FIFO = 0;
  localparam int ST_PART = 4;
  localparam int ST_PEND = 5;
  localparam int ST_ENG  = 8;
  localparam int ST_ERR  = 16;
  localparam logic [WORD_W-1:0] ST_BUSY_MASK = 32'h0000_0131;

  typedef enum logic [1:0] {PK_FILL, PK_COPY, PK_MODE} pkt_e;

  typedef struct packed {
    logic       pop;
    logic       loadArg;
    logic [1:0] argSel;
    logic       loadMode;
    logic       latchColor;
    logic       flagErr;
  } strobe_t;
endpackage

// File: rtl/draw_cmd_fifo.sv
module draw_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign pushOk   = push && !full && !flush;
  assign popOk    = pop && !empty && !flush;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= bump(wrPtr);
      if (popOk)  rdPtr <= bump(rdPtr);
      case ({pushOk, popOk})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/draw_cmd_ctrl.sv
module draw_cmd_ctrl
  import draw_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              fifoEmpty,
  input  logic [WORD_W-1:0] headWord,
  input  logic              reqReady,
  output strobe_t           strobe,
  output logic              reqValid,
  output logic              reqIsCopy,
  output logic              midPacket
);
  logic       inPkt;
  pkt_e       curKind, hdrKind;
  logic [1:0] remain, argIdx, hdrLen;
  logic       hdrKnown, canPop;

  always_comb begin
    hdrKnown = 1'b1;
    hdrKind  = PK_FILL;
    hdrLen   = LEN_FILL;
    if (headWord == HDR_FILL) begin
      hdrKind = PK_FILL;
      hdrLen  = LEN_FILL;
    end else if (headWord[31:24] == OP_COPY) begin
      hdrKind = PK_COPY;
      hdrLen  = LEN_COPY;
    end else if (headWord == HDR_MODE) begin
      hdrKind = PK_MODE;
      hdrLen  = LEN_MODE;
    end else begin
      hdrKnown = 1'b0;
    end
  end

  assign canPop    = !fifoEmpty && !reqValid && !softRst;
  assign midPacket = inPkt;

  always_comb begin
    strobe     = '0;
    strobe.pop = canPop;
    if (canPop) begin
      if (!inPkt) begin
        strobe.flagErr = !hdrKnown;
      end else begin
        if (curKind == PK_MODE) begin
          strobe.loadMode = 1'b1;
        end else begin
          strobe.loadArg = 1'b1;
          strobe.argSel  = argIdx;
        end
        strobe.latchColor = (remain == 2'd1) && (curKind == PK_FILL);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt     <= 1'b0;
      curKind   <= PK_FILL;
      remain    <= '0;
      argIdx    <= '0;
      reqValid  <= 1'b0;
      reqIsCopy <= 1'b0;
    end else if (softRst) begin
      inPkt    <= 1'b0;
      remain   <= '0;
      argIdx   <= '0;
      reqValid <= 1'b0;
    end else begin
      if (reqValid && reqReady) reqValid <= 1'b0;
      if (canPop) begin
        if (!inPkt) begin
          if (hdrKnown) begin
            inPkt   <= 1'b1;
            curKind <= hdrKind;
            remain  <= hdrLen;
            argIdx  <= '0;
          end
        end else begin
          remain <= remain - 1'b1;
          argIdx <= argIdx + 1'b1;
          if (remain == 2'd1) begin
            inPkt <= 1'b0;
            if (curKind != PK_MODE) begin
              reqValid  <= 1'b1;
              reqIsCopy <= (curKind == PK_COPY);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/draw_cmd_dpath.sv
module draw_cmd_dpath
  import draw_cmd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  input  strobe_t            strobe,
  input  logic               reqValid,
  input  logic               reqIsCopy,
  input  logic               midPacket,
  input  logic               engBusy,
  output logic               fifoEmpty,
  output logic [WORD_W-1:0]  headWord,
  output logic [LVL_W-1:0]   fifoLevel,
  output logic [COORD_W-1:0] reqSrcX,
  output logic [COORD_W-1:0] reqSrcY,
  output logic [COORD_W-1:0] reqDstX,
  output logic [COORD_W-1:0] reqDstY,
  output logic [COORD_W-1:0] reqWidth,
  output logic [COORD_W-1:0] reqHeight,
  output logic [WORD_W-1:0]  reqColor,
  output logic               cfgPix16,
  output logic [COORD_W-1:0] cfgPitch,
  output logic [COORD_W-1:0] clipXMin,
  output logic [COORD_W-1:0] clipXMax,
  output logic [COORD_W-1:0] clipYMin,
  output logic [COORD_W-1:0] clipYMax,
  output logic               errFlag
);
  logic fifoPush, fifoFull, overflowWr;
  logic [WORD_W-1:0] colorReg, statusWord, slotsWord;
  logic [WORD_W-1:0] argReg [ARG_SLOTS];
  logic [WORD_W-1:0] srcWord, dstWord, sizeWord;

  assign fifoPush   = regWrEn && (regAddr == A_FIFO) && !softRst;
  assign overflowWr = fifoPush && fifoFull;

  draw_cmd_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk(clk), .rstN(rstN), .flush(softRst), .push(fifoPush),
    .wrData(regWrData), .pop(strobe.pop), .headData(headWord),
    .level(fifoLevel), .full(fifoFull), .empty(fifoEmpty)
  );

  for (genvar i = 0; i < ARG_SLOTS; i++) begin : g_arg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) argReg[i] <= '0;
      else if (strobe.loadArg && strobe.argSel == 2'(i)) argReg[i] <= headWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colorReg <= '0;
      cfgPitch <= '0;
      clipXMin <= '0;
      clipXMax <= '0;
      clipYMin <= '0;
      clipYMax <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_COLOR: colorReg <= regWrData;
        A_PITCH: cfgPitch <= regWrData[COORD_W-1:0];
        A_XMIN:  clipXMin <= regWrData[COORD_W-1:0];
        A_XMAX:  clipXMax <= regWrData[COORD_W-1:0];
        A_YMIN:  clipYMin <= regWrData[COORD_W-1:0];
        A_YMAX:  clipYMax <= regWrData[COORD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPix16 <= 1'b0;
      reqColor <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (strobe.loadMode)   cfgPix16 <= headWord[15];
      if (strobe.latchColor) reqColor <= colorReg;
      if (softRst)                               errFlag <= 1'b0;
      else if (strobe.flagErr || overflowWr)     errFlag <= 1'b1;
    end
  end

  assign srcWord  = reqIsCopy ? argReg[0] : '0;
  assign dstWord  = reqIsCopy ? argReg[1] : argReg[0];
  assign sizeWord = reqIsCopy ? argReg[2] : argReg[1];

  assign reqSrcX   = srcWord[COORD_W-1:0];
  assign reqSrcY   = srcWord[WORD_W-1:COORD_W];
  assign reqDstX   = dstWord[COORD_W-1:0];
  assign reqDstY   = dstWord[WORD_W-1:COORD_W];
  assign reqWidth  = sizeWord[COORD_W-1:0];
  assign reqHeight = sizeWord[WORD_W-1:COORD_W];

  always_comb begin
    statusWord          = '0;
    statusWord[ST_FIFO] = !fifoEmpty;
    statusWord[ST_PART] = midPacket;
    statusWord[ST_PEND] = reqValid;
    statusWord[ST_ENG]  = engBusy;
    statusWord[ST_ERR]  = errFlag;
  end

  assign slotsWord = WORD_W'(DEPTH) - WORD_W'(fifoLevel);

  always_comb begin
    case (regAddr)
      A_SLOTS:  regRdData = slotsWord;
      A_STATUS: regRdData = statusWord;
      A_COLOR:  regRdData = colorReg;
      A_PITCH:  regRdData = WORD_W'(cfgPitch);
      A_XMIN:   regRdData = WORD_W'(clipXMin);
      A_XMAX:   regRdData = WORD_W'(clipXMax);
      A_YMIN:   regRdData = WORD_W'(clipYMin);
      A_YMAX:   regRdData = WORD_W'(clipYMax);
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/draw_cmd_front.sv
module draw_cmd_front
  import draw_cmd_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  input  logic               engBusy,
  output logic               reqValid,
  input  logic               reqReady,
  output logic               reqIsCopy,
  output logic [COORD_W-1:0] reqSrcX,
  output logic [COORD_W-1:0] reqSrcY,
  output logic [COORD_W-1:0] reqDstX,
  output logic [COORD_W-1:0] reqDstY,
  output logic [COORD_W-1:0] reqWidth,
  output logic [COORD_W-1:0] reqHeight,
  output logic [WORD_W-1:0]  reqColor,
  output logic               cfgPix16,
  output logic [COORD_W-1:0] cfgPitch,
  output logic [COORD_W-1:0] clipXMin,
  output logic [COORD_W-1:0] clipXMax,
  output logic [COORD_W-1:0] clipYMin,
  output logic [COORD_W-1:0] clipYMax,
  output logic               errFlag
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  strobe_t           strobe;
  logic              fifoEmpty, midPacket;
  logic [WORD_W-1:0] headWord;
  logic [LVL_W-1:0]  fifoLevel;

  draw_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .fifoEmpty(fifoEmpty),
    .headWord(headWord), .reqReady(reqReady), .strobe(strobe),
    .reqValid(reqValid), .reqIsCopy(reqIsCopy), .midPacket(midPacket)
  );

  draw_cmd_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .softRst(softRst), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .reqValid(reqValid), .reqIsCopy(reqIsCopy),
    .midPacket(midPacket), .engBusy(engBusy), .fifoEmpty(fifoEmpty),
    .headWord(headWord), .fifoLevel(fifoLevel),
    .reqSrcX(reqSrcX), .reqSrcY(reqSrcY), .reqDstX(reqDstX), .reqDstY(reqDstY),
    .reqWidth(reqWidth), .reqHeight(reqHeight), .reqColor(reqColor),
    .cfgPix16(cfgPix16), .cfgPitch(cfgPitch), .clipXMin(clipXMin),
    .clipXMax(clipXMax), .clipYMin(clipYMin), .clipYMax(clipYMax),
    .errFlag(errFlag)
  );
endmodule

// File: rtl/draw_cmd_front_chk.sv
module draw_cmd_front_chk
  import draw_cmd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               softRst,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [WORD_W-1:0]  regRdData,
  input logic               reqValid,
  input logic               reqReady,
  input logic               reqIsCopy,
  input logic [COORD_W-1:0] reqDstX,
  input logic [COORD_W-1:0] reqDstY,
  input logic [COORD_W-1:0] reqWidth,
  input logic [COORD_W-1:0] reqHeight,
  input logic [WORD_W-1:0]  reqColor,
  input logic               errFlag,
  input logic [LVL_W-1:0]   fifoLevel
);
  // R7: pending request holds
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady && !softRst |=> reqValid && $stable(reqIsCopy) &&
      $stable(reqDstX) && $stable(reqDstY) && $stable(reqWidth) &&
      $stable(reqHeight) && $stable(reqColor));

  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !softRst |=> errFlag);

  // R11: soft reset clears the command path
  p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !reqValid && !errFlag && fifoLevel == '0);

  // R9: write into a full FIFO flags an error
  p_overflow_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == A_FIFO && fifoLevel == LVL_W'(DEPTH) && !softRst |=> errFlag);

  // R2: occupancy never exceeds depth
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));

  // R6: busy mask nonzero while FIFO holds words
  p_status_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == A_STATUS && fifoLevel != '0 |-> (regRdData & ST_BUSY_MASK) != '0);
endmodule

bind draw_cmd_front draw_cmd_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .regWrEn(regWrEn),
  .regAddr(regAddr), .regRdData(regRdData), .reqValid(reqValid),
  .reqReady(reqReady), .reqIsCopy(reqIsCopy), .reqDstX(reqDstX),
  .reqDstY(reqDstY), .reqWidth(reqWidth), .reqHeight(reqHeight),
  .reqColor(reqColor), .errFlag(errFlag), .fifoLevel(fifoLevel)
);

// File: tb/draw_cmd_front_test.sv
`timescale 1ns/1ps
module draw_cmd_front_test;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic        isCopy;
    logic [15:0] sx, sy, dx, dy, w, h;
    logic [31:0] color;
  } item_t;

  logic clk = 1'b0, rstN = 1'b0, softRst = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [31:0] regWrData = '0, regRdData;
  logic engBusy = 1'b0, reqReady = 1'b0;
  logic reqValid, reqIsCopy, cfgPix16, errFlag;
  logic [15:0] reqSrcX, reqSrcY, reqDstX, reqDstY, reqWidth, reqHeight;
  logic [15:0] cfgPitch, clipXMin, clipXMax, clipYMin, clipYMax;
  logic [31:0] reqColor;

  int tests = 0, fails = 0;
  item_t expQ[$];

  always #4 clk = ~clk;

  draw_cmd_front #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engBusy(engBusy), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsCopy(reqIsCopy), .reqSrcX(reqSrcX), .reqSrcY(reqSrcY),
    .reqDstX(reqDstX), .reqDstY(reqDstY), .reqWidth(reqWidth),
    .reqHeight(reqHeight), .reqColor(reqColor), .cfgPix16(cfgPix16),
    .cfgPitch(cfgPitch), .clipXMin(clipXMin), .clipXMax(clipXMax),
    .clipYMin(clipYMin), .clipYMax(clipYMax), .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFill(input logic [15:0] x, y, w, h, input logic [31:0] col);
    item_t it;
    it = '{isCopy: 1'b0, sx: 16'd0, sy: 16'd0, dx: x, dy: y, w: w, h: h, color: col};
    expQ.push_back(it);
    wr(4'd0, 32'h0941_0000);
    wr(4'd0, {y, x});
    wr(4'd0, {h, w});
  endtask

  task automatic sendCopy(input logic [15:0] sx, sy, dx, dy, w, h);
    item_t it;
    it = '{isCopy: 1'b1, sx: sx, sy: sy, dx: dx, dy: dy, w: w, h: h, color: 32'd0};
    expQ.push_back(it);
    wr(4'd0, 32'h0D46_0000);
    wr(4'd0, {sy, sx});
    wr(4'd0, {dy, dx});
    wr(4'd0, {h, w});
  endtask

  // Scoreboard monitor: sample half a cycle before the accepting edge
  always @(negedge clk) begin
    #1;
    if (rstN && reqValid && reqReady) begin
      item_t act, exp;
      act = '{isCopy: reqIsCopy, sx: reqSrcX, sy: reqSrcY, dx: reqDstX, dy: reqDstY,
              w: reqWidth, h: reqHeight, color: reqColor};
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R3/R4 unexpected request: actual dst 0x%04h%04h expected none", reqDstY, reqDstX);
      end else begin
        exp = expQ.pop_front();
        if (exp.isCopy) act.color = exp.color;
        if (act !== exp) begin
          fails++;
          $display("FAIL R3/R4 request: actual %h expected %h", act, exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    rd(4'd1, v); check("R1 slots", v, DEPTH);
    rd(4'd2, v); check("R1 status", v, 32'h0);
    check("R1 reqValid", {31'd0, reqValid}, 32'd0);
    check("R1 errFlag", {31'd0, errFlag}, 32'd0);

    // R10 direct registers
    wr(4'd3, 32'h00AB_CDEF);
    wr(4'd4, 32'd640);
    wr(4'd5, 32'd2); wr(4'd6, 32'd639); wr(4'd7, 32'd3); wr(4'd8, 32'd479);
    idle(1);
    check("R10 pitch port", {16'd0, cfgPitch}, 32'd640);
    check("R10 xmin port", {16'd0, clipXMin}, 32'd2);
    check("R10 xmax port", {16'd0, clipXMax}, 32'd639);
    check("R10 ymin port", {16'd0, clipYMin}, 32'd3);
    check("R10 ymax port", {16'd0, clipYMax}, 32'd479);
    rd(4'd6, v); check("R10 xmax read", v, 32'd639);
    rd(4'd3, v); check("R10 colour read", v, 32'h00AB_CDEF);

    // R6 engine busy bit
    engBusy = 1'b1;
    rd(4'd2, v); check("R6 engine bit", v, 32'h100);
    engBusy = 1'b0;

    // R3 R7 R2: fill held while engine not ready, then copy queued
    reqReady = 1'b0;
    sendFill(16'd7, 16'd5, 16'd4, 16'd3, 32'h00AB_CDEF);
    idle(4);
    check("R7 pending valid", {31'd0, reqValid}, 32'd1);
    wr(4'd3, 32'h0000_0011);   // must not alter the pending fill (R3)
    sendCopy(16'd10, 16'd20, 16'd30, 16'd40, 16'd8, 16'd9);
    idle(3);
    rd(4'd1, v); check("R2 slots with 4 held", v, DEPTH - 4);
    rd(4'd2, v); check("R6 status pending", v, 32'h21);
    check("R7 still valid", {31'd0, reqValid}, 32'd1);
    reqReady = 1'b1;
    idle(12);
    rd(4'd2, v); check("R6 status idle", v, 32'h0);
    rd(4'd1, v); check("R2 slots drained", v, DEPTH);
    sendFill(16'd1, 16'd2, 16'd100, 16'd50, 32'h0000_0011);
    sendCopy(16'd50, 16'd0, 16'd0, 16'd50, 16'd16, 16'd16);
    idle(12);

    // R5 mode packet
    wr(4'd0, 32'hF101_0108); wr(4'd0, 32'h0000_8300);
    idle(4);
    check("R5 pix16 set", {31'd0, cfgPix16}, 32'd1);
    check("R5 no request", {31'd0, reqValid}, 32'd0);
    wr(4'd0, 32'hF101_0108); wr(4'd0, 32'h0000_0300);
    idle(4);
    check("R5 pix16 clear", {31'd0, cfgPix16}, 32'd0);
    wr(4'd0, 32'hF101_0108); wr(4'd0, 32'h0000_8300);
    idle(4);

    // R11 partial packet and soft reset
    wr(4'd0, 32'h0D44_0000); wr(4'd0, 32'h0001_0001);
    idle(4);
    rd(4'd2, v); check("R6 partial packet", v, 32'h10);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    rd(4'd2, v); check("R11 status after soft", v, 32'h0);
    rd(4'd1, v); check("R11 slots after soft", v, DEPTH);
    check("R11 pitch kept", {16'd0, cfgPitch}, 32'd640);
    check("R11 pix16 kept", {31'd0, cfgPix16}, 32'd1);
    sendFill(16'd3, 16'd3, 16'd3, 16'd3, 32'h0000_0011);
    idle(8);

    // R8 unknown header
    wr(4'd0, 32'h1234_5678);
    sendFill(16'd9, 16'd8, 16'd7, 16'd6, 32'h0000_0011);
    idle(8);
    check("R8 error set", {31'd0, errFlag}, 32'd1);
    rd(4'd2, v); check("R8 status err bit", v, 32'h1_0000);
    idle(3);
    check("R11 error sticky", {31'd0, errFlag}, 32'd1);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    check("R11 error cleared", {31'd0, errFlag}, 32'd0);

    // R9 overflow
    reqReady = 1'b0;
    sendFill(16'd11, 16'd12, 16'd13, 16'd14, 32'h0000_0011);
    idle(5);
    for (int i = 0; i < DEPTH / 4; i++)
      sendCopy(16'(i), 16'(i + 1), 16'(i + 2), 16'(i + 3), 16'd4, 16'd4);
    rd(4'd1, v); check("R9 slots full", v, 32'd0);
    check("R9 no error yet", {31'd0, errFlag}, 32'd0);
    wr(4'd0, 32'h0941_0000);
    idle(1);
    check("R9 overflow error", {31'd0, errFlag}, 32'd1);
    rd(4'd1, v); check("R9 slots still zero", v, 32'd0);
    reqReady = 1'b1;
    idle(40);
    rd(4'd1, v); check("R9 drained", v, DEPTH);
    check("R9 nothing left", {31'd0, reqValid}, 32'd0);
    check("R3/R4 queue empty", expQ.size(), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule